// File: doc/BRIEF.md
# PC Card Socket Strobe Sequencer

This block turns single CPU requests into bus cycles for a PC Card style socket that occupies one 64 MB window of the address map. The lower 32 MB of the window reaches the card's common memory, and the upper 32 MB reaches its I/O space. Memory cycles use an output-enable and write-enable pair. I/O cycles use a separate I/O read and I/O write pair. Both kinds drive the two card enables, which select the byte lanes.

The block's clock `clk` is the half-cycle timebase, so one bus cycle is two `clk` periods. This lets the address setup before the strobe and the hold after it be set in half-cycle steps. A wait count lengthens the strobe. A request is accepted when `req_valid` and `req_ready` are both high. The block drives the access and then gives one `rsp_valid` pulse, which carries the read data. Configuration is sampled when the request is accepted.

Top module: `pcs_strobe_seq`

## Requirements
- R1: After reset and whenever idle, `ce1_n`, `ce2_n`, `oe_n`, `we_n`, `iord_n` and `iowr_n` are all high, `data_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: Address bits 31:29 are ignored. Bits 28:26 = 110 with bit 25 = 0 select memory space, and bits 28:26 = 110 with bit 25 = 1 select I/O space. Any other value is accepted and dropped, with no enable, no strobe and no response.
- R3: A memory read pulses `oe_n`, a memory write pulses `we_n`, an I/O read pulses `iord_n` and an I/O write pulses `iowr_n`. No more than one of the four is ever low.
- R4: A 16-bit access (`req_wide`=1) drives both card enables low. A byte access drives only `ce1_n` low at an even address (bit 0 = 0) and only `ce2_n` low at an odd address.
- R5: The strobe falls 2·S+1 clk periods after the card enables fall, where S is the 2-bit `cfg_setup` (00=0.5, 01=1.5, 10=2.5, 11=3.5 bus cycles).
- R6: The strobe stays low for 2+2·min(W,10) clk periods, where W is `cfg_wait`. Values above 10 act as 10.
- R7: The card enables rise 2·H+1 clk periods after the strobe rises, where H is the 2-bit `cfg_hold` (same encoding as R5).
- R8: `rsp_valid` is high for exactly one clk, in the same cycle in which the enables rise. For reads, `rsp_rdata` holds the card data sampled when the strobe ended. A wide access returns all 16 bits. A byte access returns bits 7:0 for an even address and bits 15:8 for an odd address, zero-extended.
- R9: During a write, `data_oe` is high while the enables are low. `card_wdata` carries the 16-bit word on a wide write, or the byte copied onto both lanes on a byte write. `data_oe` stays low on reads.
- R10: `card_addr` equals request address bits 24:0 for the whole time the enables are low.
- R11: A change to `cfg_setup`, `cfg_hold` or `cfg_wait` during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this edge |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| cfg_setup | input | 2 | Setup code, enable-to-strobe |
| cfg_hold | input | 2 | Hold code, strobe-to-enable release |
| cfg_wait | input | 4 | Wait cycles added to strobe |
| card_addr | output | 25 | Card address |
| card_wdata | output | 16 | Data driven to card |
| data_oe | output | 1 | Write data drive enable |
| card_rdata | input | 16 | Data returned by card |
| ce1_n | output | 1 | Card enable, even lane |
| ce2_n | output | 1 | Card enable, odd lane |
| oe_n | output | 1 | Memory read strobe |
| we_n | output | 1 | Memory write strobe |
| iord_n | output | 1 | I/O read strobe |
| iowr_n | output | 1 | I/O write strobe |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read result |

## Verification
The bench follows every access cycle by cycle and compares the enables and strobes against a timeline it computes from the setup, wait and hold codes. An off-by-one counter therefore shows up as a strobe that is one half-cycle early or late. Wait codes above ten are driven to catch a missing clamp, which would stretch the strobe. Odd byte addresses catch swapped enables or a wrong read lane. Addresses with the upper bits set, and addresses outside the window, catch a decoder that looks at bits it should ignore or that answers for the wrong space. Configuration is changed in the middle of some accesses, which exposes a design that reads the live fields instead of the sampled ones.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} pcs_state_e;

  // half-cycle code (0.5 + n cycles) to clk ticks
  function automatic logic [2:0] half_code_ticks(input logic [1:0] code);
    return {code, 1'b1};
  endfunction
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode #(
  parameter int ADDR_W = 32,
  parameter int CARD_AW = 25,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] WINDOW_TAG = 3'b110
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              hit,
  output logic              io_space,
  output logic [1:0]        lane_en
);
  localparam int TAG_LO = CARD_AW + 1;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  assign hit      = (addr[TAG_HI:TAG_LO] == WINDOW_TAG);
  assign io_space = addr[CARD_AW];

  always_comb begin
    if (wide) lane_en = 2'b11;
    else      lane_en = addr[0] ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/pcs_span.sv
module pcs_span #(
  parameter int WAIT_MAX = 10,
  parameter int CNT_W = 5
) (
  input  logic [1:0]       setup_code,
  input  logic [1:0]       hold_code,
  input  logic [3:0]       wait_code,
  output logic [CNT_W-1:0] setup_ticks,
  output logic [CNT_W-1:0] strobe_ticks,
  output logic [CNT_W-1:0] hold_ticks
);
  import pcs_pkg::*;
  logic [3:0] wait_eff;

  assign wait_eff     = (32'(wait_code) > WAIT_MAX) ? 4'(WAIT_MAX) : wait_code;
  assign setup_ticks  = CNT_W'(half_code_ticks(setup_code));
  assign hold_ticks   = CNT_W'(half_code_ticks(hold_code));
  assign strobe_ticks = CNT_W'(2) + CNT_W'({wait_eff, 1'b0});
endmodule

// File: rtl/pcs_lane.sv
module pcs_lane #(
  parameter int DATA_W = 16
) (
  input  logic              wide,
  input  logic              odd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] card_word,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int HALF = DATA_W / 2;

  assign bus_wdata = wide ? cpu_wdata : {2{cpu_wdata[HALF-1:0]}};

  always_comb begin
    if (wide)     cpu_rdata = card_word;
    else if (odd) cpu_rdata = {{HALF{1'b0}}, card_word[DATA_W-1:HALF]};
    else          cpu_rdata = {{HALF{1'b0}}, card_word[HALF-1:0]};
  end
endmodule

// File: rtl/pcs_strobe_seq.sv
module pcs_strobe_seq #(
  parameter int ADDR_W = 32,
  parameter int CARD_AW = 25,
  parameter int DATA_W = 16,
  parameter int WAIT_MAX = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [1:0]         cfg_setup,
  input  logic [1:0]         cfg_hold,
  input  logic [3:0]         cfg_wait,
  output logic [CARD_AW-1:0] card_addr,
  output logic [DATA_W-1:0]  card_wdata,
  output logic               data_oe,
  input  logic [DATA_W-1:0]  card_rdata,
  output logic               ce1_n,
  output logic               ce2_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               iord_n,
  output logic               iowr_n,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  import pcs_pkg::*;
  localparam int CNT_W = $clog2(2 * WAIT_MAX + 3);

  pcs_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stb_len_q, hold_len_q;
  logic             io_q, wr_q, wide_q, odd_q;

  logic             dec_hit, dec_io;
  logic [1:0]       dec_lanes;
  logic [CNT_W-1:0] setup_ticks, strobe_ticks, hold_ticks;
  logic [DATA_W-1:0] steer_wdata, steer_rdata;
  logic             accept;

  pcs_decode #(.ADDR_W(ADDR_W), .CARD_AW(CARD_AW)) u_dec (
    .addr(req_addr), .wide(req_wide),
    .hit(dec_hit), .io_space(dec_io), .lane_en(dec_lanes)
  );

  pcs_span #(.WAIT_MAX(WAIT_MAX), .CNT_W(CNT_W)) u_span (
    .setup_code(cfg_setup), .hold_code(cfg_hold), .wait_code(cfg_wait),
    .setup_ticks(setup_ticks), .strobe_ticks(strobe_ticks), .hold_ticks(hold_ticks)
  );

  pcs_lane #(.DATA_W(DATA_W)) u_lane (
    .wide(wide_q), .odd(odd_q), .cpu_wdata(req_wdata), .card_word(card_rdata),
    .bus_wdata(steer_wdata), .cpu_rdata(steer_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // wide_q must reflect the new request for write steering at accept
  logic [DATA_W-1:0] accept_wdata;
  assign accept_wdata = req_wide ? req_wdata : {2{req_wdata[DATA_W/2-1:0]}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      stb_len_q  <= '0;
      hold_len_q <= '0;
      io_q       <= 1'b0;
      wr_q       <= 1'b0;
      wide_q     <= 1'b0;
      odd_q      <= 1'b0;
      card_addr  <= '0;
      card_wdata <= '0;
      data_oe    <= 1'b0;
      ce1_n      <= 1'b1;
      ce2_n      <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      iord_n     <= 1'b1;
      iowr_n     <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept && dec_hit) begin
            io_q       <= dec_io;
            wr_q       <= req_write;
            wide_q     <= req_wide;
            odd_q      <= req_addr[0];
            stb_len_q  <= strobe_ticks;
            hold_len_q <= hold_ticks;
            card_addr  <= req_addr[CARD_AW-1:0];
            card_wdata <= accept_wdata;
            data_oe    <= req_write;
            ce1_n      <= ~dec_lanes[0];
            ce2_n      <= ~dec_lanes[1];
            cnt        <= setup_ticks - CNT_W'(1);
            state      <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            oe_n   <= ~(!io_q && !wr_q);
            we_n   <= ~(!io_q &&  wr_q);
            iord_n <= ~( io_q && !wr_q);
            iowr_n <= ~( io_q &&  wr_q);
            cnt    <= stb_len_q - CNT_W'(1);
            state  <= ST_STROBE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            iord_n <= 1'b1;
            iowr_n <= 1'b1;
            if (!wr_q) rsp_rdata <= steer_rdata;
            cnt    <= hold_len_q - CNT_W'(1);
            state  <= ST_HOLD;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            ce1_n     <= 1'b1;
            ce2_n     <= 1'b1;
            data_oe   <= 1'b0;
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_steer;
  assign unused_steer = ^steer_wdata;
endmodule

// File: rtl/pcs_strobe_checker.sv
module pcs_strobe_checker #(
  parameter int CARD_AW = 25
) (
  input logic               clk,
  input logic               rst,
  input logic               ce1_n,
  input logic               ce2_n,
  input logic               oe_n,
  input logic               we_n,
  input logic               iord_n,
  input logic               iowr_n,
  input logic               data_oe,
  input logic               rsp_valid,
  input logic               req_ready,
  input logic [CARD_AW-1:0] card_addr
);
  logic ce_any, stb_any;
  assign ce_any  = !ce1_n || !ce2_n;
  assign stb_any = !oe_n || !we_n || !iord_n || !iowr_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~oe_n, ~we_n, ~iord_n, ~iowr_n}) <= 1); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!stb_any && !data_oe)); // R1
  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(stb_any) |-> $past(ce_any)); // R5
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_any) |-> !$past(stb_any)); // R7
  AST_RSP_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!ce_any && $past(ce_any))); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (ce_any && $past(ce_any)) |-> $stable(card_addr)); // R10
endmodule

bind pcs_strobe_seq pcs_strobe_checker #(.CARD_AW(CARD_AW)) u_chk (
  .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
  .iord_n(iord_n), .iowr_n(iowr_n), .data_oe(data_oe), .rsp_valid(rsp_valid),
  .req_ready(req_ready), .card_addr(card_addr)
);

// File: tb/sim_pcs_strobe_seq.sv
`timescale 1ns/1ps
module sim_pcs_strobe_seq;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_write = 0, req_wide = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_wdata = 0, card_rdata = 0, card_wdata, rsp_rdata;
  logic [1:0] cfg_setup = 0, cfg_hold = 0;
  logic [3:0] cfg_wait = 0;
  logic [24:0] card_addr;
  logic data_oe, ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n, rsp_valid;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcs_strobe_seq u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_ce_n(input logic [31:0] a, input logic w);
    if (w) return 2'b00;
    return a[0] ? 2'b01 : 2'b10; // {ce2_n, ce1_n}
  endfunction

  function automatic logic [3:0] exp_stb_n(input logic io, input logic wr);
    // {oe_n, we_n, iord_n, iowr_n}
    case ({io, wr})
      2'b00: return 4'b0111;
      2'b01: return 4'b1011;
      2'b10: return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic int wait_ticks(input logic [3:0] w);
    return 2 + 2 * ((w > 10) ? 10 : int'(w));
  endfunction

  task automatic access(input logic [31:0] a, input logic wr, input logic wide,
                        input logic [15:0] wd, input logic [15:0] cw,
                        input logic [1:0] s, input logic [1:0] h, input logic [3:0] w,
                        input bit churn);
    int ns, nw, nh, t;
    bit b_ce = 0, b_stb = 0, b_addr = 0, b_wd = 0, b_rsp = 0;
    logic [1:0] ece;
    logic [3:0] estb;
    logic [15:0] ewd, erd;
    ns = 2*s + 1; nw = wait_ticks(w); nh = 2*h + 1; t = ns + nw + nh;
    ece = exp_ce_n(a, wide);
    estb = exp_stb_n(a[25], wr);
    ewd = wide ? wd : {wd[7:0], wd[7:0]};
    erd = wide ? cw : (a[0] ? {8'h0, cw[15:8]} : {8'h0, cw[7:0]});
    @(negedge clk);
    req_addr = a; req_write = wr; req_wide = wide; req_wdata = wd; card_rdata = cw;
    cfg_setup = s; cfg_hold = h; cfg_wait = w; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    if (churn) begin cfg_setup = ~s; cfg_hold = ~h; cfg_wait = w ^ 4'h5; end
    for (int k = 0; k <= t; k++) begin
      @(negedge clk);
      if ({ce2_n, ce1_n} != ((k < t) ? ece : 2'b11)) b_ce = 1;
      if ({oe_n, we_n, iord_n, iowr_n} != ((k >= ns && k < ns + nw) ? estb : 4'hF)) b_stb = 1;
      if (k < t && card_addr != a[24:0]) b_addr = 1;
      if (data_oe != (wr && k < t)) b_wd = 1;
      if (wr && k < t && card_wdata != ewd) b_wd = 1;
      if (rsp_valid != (k == t) || req_ready != (k == t)) b_rsp = 1;
      if (k == t && !wr && rsp_rdata != erd) b_rsp = 1;
    end
    check(!b_ce, "R4/R5/R7", "enable timeline", {ce2_n, ce1_n}, ece);
    check(!b_stb, churn ? "R11" : "R3/R6", "strobe timeline", {oe_n, we_n, iord_n, iowr_n}, estb);
    check(!b_addr, "R10", "card_addr", card_addr, a[24:0]);
    if (wr) check(!b_wd, "R9", "write data", card_wdata, ewd);
    else    check(!b_rsp, "R8", "read response", rsp_rdata, erd);
  endtask

  task automatic dropped(input logic [31:0] a);
    bit bad = 0;
    @(negedge clk);
    req_addr = a; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!ce1_n || !ce2_n || !oe_n || !we_n || !iord_n || !iowr_n || rsp_valid || !req_ready) bad = 1;
    end
    check(!bad, "R2", "out-of-window access ignored", a, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check({ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n} == 6'h3F && !data_oe && !rsp_valid && req_ready,
          "R1", "idle state", {ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n, data_oe, rsp_valid, req_ready},
          9'b111111001);
    // directed corners
    access(32'h1800_0000, 0, 1, 0, 16'hA55A, 0, 0, 0, 0);        // R2 memory read, minimum timing
    access(32'hF800_0001, 0, 0, 0, 16'hBEEF, 3, 3, 0, 0);        // R2 upper bits ignored, odd byte
    access(32'h1A00_0010, 1, 0, 16'h00C3, 0, 1, 2, 4'd15, 0);    // R6 wait clamp, I/O write even
    access(32'h1BFF_FFFF, 0, 0, 0, 16'h1234, 2, 1, 4'd10, 0);    // I/O read, odd byte, max wait
    access(32'h19FF_FFFE, 1, 1, 16'h9876, 0, 0, 3, 4'd3, 1);     // R11 churn
    dropped(32'h1C00_0000);
    dropped(32'h0400_0000);
    dropped(32'h3800_0000 ^ 32'h0400_0000);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = {3'($urandom), 3'b110, 1'($urandom), 25'($urandom)};
      access(a, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
             2'($urandom), 2'($urandom), 4'($urandom), ($urandom % 4) == 0);
    end
    @(negedge clk);
    check({ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n} == 6'h3F && req_ready, "R1", "idle at end",
          {ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n}, 6'h3F);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule